// File: doc/BRIEF.md
# Shadowed Real-Time-Clock Host Port

This block sits between a byte-wide host bus and a free-running calendar counter block. The host sees one flat byte address space. The top eight addresses hold a control byte and seven time bytes: seconds, minutes, hours, weekday, day of month, month and year. Every lower address is plain read/write storage. The host never touches the live counters directly. It reads and writes a user copy of the time bytes, and the block keeps that copy in step with the counters.

With both halt bits clear, the user copy is reloaded from the live counters on each 1 Hz tick. Setting the freeze bit holds the copy, so the host can read a consistent snapshot while the counters keep running. Setting the stage bit also holds the copy, so the host can write new time values into it. Clearing the stage bit sends those values to the counter block as a one-cycle commit pulse with the staged vector. When the frequency-test bit is set and the oscillator is running, bit 0 of a seconds read follows a 512 Hz test signal.

The address width is a parameter. A width of 13 gives an 8K-byte space, and the default of 11 keeps the storage array small.

Top module: `rtc_host_if`

## Requirements
- R1: A write with address below 2^ADDR_W-8 stores the byte, and a later read of that address returns it.
- R2: Address 2^ADDR_W-8 is the control byte, and all 8 bits read back as written. Bit 7 is the stage bit and bit 6 is the freeze bit. Bits 5..0 have no function.
- R3: With bits 7 and 6 of the control byte both 0, a 1 Hz tick loads all seven time bytes from live_time_i in one cycle. Byte k sits at address 2^ADDR_W-7+k and at live_time_i[8k+7:8k], with k=0 seconds and k=6 year. Between ticks the time bytes do not change.
- R4: While the freeze bit is 1, ticks do not change the time bytes, and reads return the values held when the bit was set.
- R5: After the freeze bit returns to 0, the time bytes keep their held values until the next tick, and that tick loads all seven bytes together.
- R6: While the stage bit is 1, host writes to the time bytes are held and read back, and ticks do not overwrite them.
- R7: A control write that changes the stage bit from 1 to 0 raises commit_o for exactly one cycle after that write's clock edge, with commit_time_o equal to the seven time bytes. commit_o stays 0 at all other times.
- R8: With both bits set, clearing only the stage bit commits the staged bytes, and the freeze bit keeps holding the time bytes across ticks until it is cleared.
- R9: In a seconds read where weekday bit 6 is 1 and seconds bit 7 is 0, rdata_o[0] equals test_512_i and bits 7..1 are the stored bits. If seconds bit 7 is 1, bit 0 is the stored bit.
- R10: After reset the control byte and all time bytes are 0 and commit_o is 0. When cs_i is low, or in a write cycle, rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Access select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| tick_1hz_i | input | 1 | One-cycle pulse, once per second, from the counter block |
| test_512_i | input | 1 | 512 Hz test square wave |
| live_time_i | input | 56 | Live counter bytes, seconds in the low byte |
| commit_o | output | 1 | One-cycle load strobe to the counter block |
| commit_time_o | output | 56 | Staged time bytes sent with commit_o |

## Verification
The bench changes live_time_i between ticks and while each halt is held. A copy that follows the counters outside tick cycles, or ignores a halt, then shows up as wrong read data. It clears the stage bit from both the single-halt and the double-halt state, and checks that the commit pulse is one cycle wide and carries the staged bytes. A design that drops the freeze on commit would then return live values after a tick. The test-bit path is driven with the oscillator both running and stopped, so that a mux that overrides bit 0 unconditionally gives a wrong read. Random storage traffic includes the two addresses at the edge of the clock region, which catches an off-by-one in the decode.

// File: rtl/rtc_if_pkg.sv
package rtc_if_pkg;
  localparam int unsigned NTIME   = 7;
  localparam int unsigned W_BIT   = 7;
  localparam int unsigned R_BIT   = 6;
  localparam int unsigned SEC_IDX = 0;
  localparam int unsigned DAY_IDX = 3;
  localparam int unsigned FT_BIT  = 6;
  localparam int unsigned OSC_BIT = 7;
  typedef logic [7:0] byte_t;
  typedef logic [NTIME-1:0][7:0] tvec_t;
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              clk_sel_o,
  output logic [2:0]        reg_o
);
  assign clk_sel_o = &addr_i[ADDR_W-1:3];
  assign reg_o     = addr_i[2:0];
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned DEPTH = (1 << ADDR_W) - 8;

  logic [7:0] mem_q [DEPTH];
  logic       in_rng;

  assign in_rng = 32'(addr_i) < DEPTH;

  always_ff @(posedge clk_i) begin
    if (we_i && in_rng) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = in_rng ? mem_q[addr_i] : 8'h00;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_if_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] reg_i,
  input  byte_t      wdata_i,
  input  logic       tick_i,
  input  tvec_t      live_i,
  output byte_t      ctrl_o,
  output tvec_t      usr_o,
  output logic       commit_o,
  output tvec_t      commit_time_o
);
  byte_t ctrl_q;
  logic  commit_q;
  tvec_t commit_time_q;
  logic  refresh;
  logic  ctrl_wr;
  logic  w_clear;

  assign ctrl_wr = wr_i && (reg_i == 3'd0);
  assign w_clear = ctrl_wr && ctrl_q[W_BIT] && !wdata_i[W_BIT];
  // copy follows counters only on a tick with both halts clear
  assign refresh = tick_i && !ctrl_q[W_BIT] && !ctrl_q[R_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i;
  end

  for (genvar g = 0; g < NTIME; g++) begin : g_tb
    byte_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && (reg_i == 3'(g + 1))) q <= wdata_i;
      else if (refresh) q <= live_i[g];
    end
    assign usr_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q      <= 1'b0;
      commit_time_q <= '0;
    end else begin
      commit_q <= w_clear;
      if (w_clear) commit_time_q <= usr_o;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign commit_o      = commit_q;
  assign commit_time_o = commit_time_q;
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_if_pkg::*;
(
  input  logic       cs_i,
  input  logic       we_i,
  input  logic       clk_sel_i,
  input  logic [2:0] reg_i,
  input  byte_t      ram_i,
  input  byte_t      ctrl_i,
  input  tvec_t      usr_i,
  input  logic       test_i,
  output byte_t      rdata_o
);
  logic ft_on;
  assign ft_on = usr_i[DAY_IDX][FT_BIT] && !usr_i[SEC_IDX][OSC_BIT];

  always_comb begin
    rdata_o = '0;
    if (cs_i && !we_i) begin
      if (!clk_sel_i) rdata_o = ram_i;
      else begin
        case (reg_i)
          3'd0:    rdata_o = ctrl_i;
          3'd1:    rdata_o = usr_i[0];
          3'd2:    rdata_o = usr_i[1];
          3'd3:    rdata_o = usr_i[2];
          3'd4:    rdata_o = usr_i[3];
          3'd5:    rdata_o = usr_i[4];
          3'd6:    rdata_o = usr_i[5];
          default: rdata_o = usr_i[6];
        endcase
        if (reg_i == 3'd1 && ft_on) rdata_o[0] = test_i;
      end
    end
  end
endmodule

// File: rtl/rtc_host_if.sv
module rtc_host_if
  import rtc_if_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_1hz_i,
  input  logic              test_512_i,
  input  logic [55:0]       live_time_i,
  output logic              commit_o,
  output logic [55:0]       commit_time_o
);
  logic       clk_sel;
  logic [2:0] reg_sel;
  byte_t      ram_rd;
  byte_t      ctrl_w;
  tvec_t      usr_w;
  tvec_t      cmt_w;

  rtc_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i(addr_i), .clk_sel_o(clk_sel), .reg_o(reg_sel)
  );

  rtc_ram #(.ADDR_W(ADDR_W)) i_ram (
    .clk_i(clk_i), .we_i(cs_i && we_i && !clk_sel), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(ram_rd)
  );

  rtc_regs i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cs_i && we_i && clk_sel),
    .reg_i(reg_sel), .wdata_i(wdata_i), .tick_i(tick_1hz_i),
    .live_i(tvec_t'(live_time_i)), .ctrl_o(ctrl_w), .usr_o(usr_w),
    .commit_o(commit_o), .commit_time_o(cmt_w)
  );

  rtc_rd_mux i_mux (
    .cs_i(cs_i), .we_i(we_i), .clk_sel_i(clk_sel), .reg_i(reg_sel),
    .ram_i(ram_rd), .ctrl_i(ctrl_w), .usr_i(usr_w), .test_i(test_512_i),
    .rdata_o(rdata_o)
  );

  assign commit_time_o = cmt_w;
endmodule

// File: rtl/rtc_host_if_chk.sv
module rtc_host_if_chk #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              tick_1hz_i,
  input logic              test_512_i,
  input logic [55:0]       live_time_i,
  input logic              commit_o,
  input logic [7:0]        ctrl_w,
  input logic [55:0]       usr_w
);
  logic tm_wr;
  logic sec_rd;
  assign tm_wr  = cs_i && we_i && (&addr_i[ADDR_W-1:3]) && (addr_i[2:0] != 3'd0);
  assign sec_rd = cs_i && !we_i && (&addr_i[ADDR_W-1:3]) && (addr_i[2:0] == 3'd1);

  // R7
  commit_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R7
  commit_on_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(commit_o) |-> $fell(ctrl_w[7]));
  // R3
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_1hz_i && !tm_wr) |=> $stable(usr_w));
  // R3
  tick_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_1hz_i && ctrl_w[7:6] == 2'b00 && !tm_wr) |=> usr_w == $past(live_time_i));
  // R4
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_w[6] && !tm_wr) |=> $stable(usr_w));
  // R9
  test_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_rd && usr_w[30] && !usr_w[7]) |-> rdata_o[0] == test_512_i);
endmodule

bind rtc_host_if rtc_host_if_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .tick_1hz_i(tick_1hz_i), .test_512_i(test_512_i),
  .live_time_i(live_time_i), .commit_o(commit_o), .ctrl_w(ctrl_w),
  .usr_w(usr_w)
);

// File: tb/test_rtc_host_if.sv
module test_rtc_host_if;
  localparam int unsigned AW   = 11;
  localparam int unsigned BASE = (1 << AW) - 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0, we = 1'b0, tick = 1'b0, t512 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [55:0]   live = '0;
  logic          commit;
  logic [55:0]   commit_time;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_host_if #(.ADDR_W(AW)) i_rtc_host_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_1hz_i(tick), .test_512_i(t512),
    .live_time_i(live), .commit_o(commit), .commit_time_o(commit_time)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = AW'(a);
    #1 d = rdata;
    cs = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic logic [7:0] byte_of(input logic [55:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  task automatic chk_time(input string req, input logic [55:0] exp);
    logic [7:0] d;
    for (int k = 0; k < 7; k++) begin
      rd(BASE + 1 + k, d);
      chk(req, d, byte_of(exp, k));
    end
  endtask

  task automatic stage(input logic [55:0] v);
    for (int k = 0; k < 7; k++) wr(BASE + 1 + k, byte_of(v, k));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [55:0] v1, v2, st;
    int          addrs [12];
    logic [7:0]  vals  [12];
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    rd(BASE, d); chk("R10 ctrl", d, 8'h00);
    chk_time("R10 time", '0);
    chk("R10 commit", commit, 1'b0);
    @(negedge clk); cs = 1; we = 1; addr = AW'(BASE); #1 chk("R10 write-cycle rdata", rdata, 8'h00);
    cs = 0; we = 0;

    // R1 storage incl. edge addresses
    addrs[0] = 0; addrs[1] = BASE - 1;
    for (int i = 2; i < 12; i++) addrs[i] = int'($urandom_range(BASE - 2, 1));
    for (int i = 0; i < 12; i++) begin vals[i] = 8'($urandom); wr(addrs[i], vals[i]); end
    for (int i = 11; i >= 0; i--) begin
      bit later = 0;
      for (int j = i + 1; j < 12; j++) if (addrs[j] == addrs[i]) later = 1;
      if (!later) begin rd(addrs[i], d); chk("R1 storage", d, vals[i]); end
    end
    rd(BASE, d); chk("R1 ctrl untouched by storage", d, 8'h00);

    // R2 control storage bits
    wr(BASE, 8'h2A); rd(BASE, d); chk("R2 ctrl readback", d, 8'h2A);
    wr(BASE, 8'h00);

    // R3 tick load and hold between ticks
    for (int n = 0; n < 4; n++) begin
      v1 = {$urandom, $urandom} & 56'h7F_FFFF_FFFF_FFFF;
      live = v1; pulse_tick();
      chk_time("R3 tick load", v1);
      live = {$urandom, $urandom};
      repeat (3) @(negedge clk);
      chk_time("R3 hold between ticks", v1);
    end

    // R4 freeze
    live = 56'h11_22_33_04_15_26_37; pulse_tick();
    v1 = live;
    wr(BASE, 8'h40);
    live = 56'h99_88_77_06_55_44_33; pulse_tick(); pulse_tick();
    chk_time("R4 frozen", v1);
    rd(BASE, d); chk("R4 ctrl", d, 8'h40);

    // R5 release then refresh on tick
    wr(BASE, 8'h00);
    chk_time("R5 held until tick", v1);
    v2 = 56'h24_12_31_07_23_59_58; live = v2; pulse_tick();
    chk_time("R5 refreshed", v2);

    // R6 stage
    wr(BASE, 8'h80);
    st = 56'h25_01_15_02_10_20_30;
    stage(st);
    live = 56'h01_01_01_01_01_01_01; pulse_tick();
    chk_time("R6 staged held", st);
    chk("R6 no commit", commit, 1'b0);

    // R7 commit pulse
    wr(BASE, 8'h00);
    chk("R7 commit high", commit, 1'b1);
    chk("R7 commit data", commit_time, st);
    @(negedge clk); chk("R7 commit one cycle", commit, 1'b0);
    wr(BASE, 8'h00); chk("R7 no commit without 1->0", commit, 1'b0);

    // R8 both halts
    wr(BASE, 8'hC0);
    st = 56'h30_06_20_05_08_09_10; stage(st);
    wr(BASE, 8'h40);
    chk("R8 commit high", commit, 1'b1);
    chk("R8 commit data", commit_time, st);
    live = 56'h31_07_21_06_09_10_11; pulse_tick();
    chk_time("R8 still frozen", st);
    wr(BASE, 8'h00); pulse_tick();
    chk_time("R8 released", live);

    // R9 frequency test: weekday bit6=1, seconds bit7=0
    live = 56'h20_03_04_45_12_34_56; pulse_tick();
    t512 = 0; rd(BASE + 1, d); chk("R9 bit0 low", d, 8'h56);
    t512 = 1; rd(BASE + 1, d); chk("R9 bit0 high", d, 8'h57);
    rd(BASE + 2, d); chk("R9 other reg", d, 8'h34);
    // oscillator stopped: no override
    live = 56'h20_03_04_45_12_34_D6; pulse_tick();
    t512 = 1; rd(BASE + 1, d); chk("R9 osc stopped", d, 8'hD6);
    t512 = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule